// File: doc/BRIEF.md
# Per-Input Layer Selector with Sliding-Window Lockout

This block sits in the per-input demultiplexor of a switch built from several identical, slower switching layers running in parallel. For each cell arriving on its input it picks one layer to send the cell to. The picked layer must satisfy two conditions. It must be free on the input side, meaning this input has not started a cell to it within the recent lockout window. It must also be allowed by every destination-side availability mask that applies to the cell. A unicast cell has one such mask. A multicast cell has one mask per destination output.

Each layer has a small down-counter. The counter is loaded when the layer is picked and counts down once per slot tick. A layer is free on the input side while its counter is zero. When more than one layer qualifies, the lowest-numbered one wins. When no layer qualifies, nothing is picked and no layer is locked. The current input-side free mask is brought out so that a central or distributed scheduler can combine it with its own view.

Top module: `lane_select`

## Requirements
- R1: After reset every layer is free (`avail_mask` all ones) and `pick_found` is low.
- R2: Bit l of `avail_mask` is high exactly when layer l is not locked. A locked bit can only return high in the cycle after a `slot_tick`.
- R3: When `pick_found` is high, `pick_layer` is free in `avail_mask` and its bit is set in every destination mask whose `dest_en` bit is high. A destination mask whose `dest_en` bit is low has no effect. With `dest_en` all zero, only the input side constrains the choice. Destination mask f occupies bits `[f*NUM_LAYERS +: NUM_LAYERS]` of `dest_mask`, and bit l of it stands for layer l.
- R4: Among the qualifying layers, `pick_layer` is the lowest-numbered one.
- R5: If `cell_valid` is low or no layer qualifies, `pick_found` is low, `pick_layer` is 0, and no layer becomes locked.
- R6: A cell is accepted when `cell_valid` and `pick_found` are both high at a clock edge. The accepted layer is then locked from the next cycle on. It becomes free again after exactly `HOLD_SLOTS-1` further slot ticks, and a tick in the accept cycle itself is not counted.
- R7: A slot tick in the same cycle as an accept still counts down every other locked layer. For the accepted layer, the reload takes precedence over the count.
- R8: Without accepts, `HOLD_SLOTS-1` slot ticks make every layer free again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One-cycle strobe marking the end of a time slot |
| cell_valid | input | 1 | A cell needs a layer in this cycle |
| dest_en | input | FANOUT | Which destination masks apply to this cell |
| dest_mask | input | FANOUT*NUM_LAYERS | Destination-side availability masks, one per fanout slot |
| pick_found | output | 1 | A qualifying layer exists for a valid cell |
| pick_layer | output | IDX_W | Index of the chosen layer (0 when none) |
| avail_mask | output | NUM_LAYERS | Input-side free layers |

## Verification
The collision of interest is an accept and a slot tick in the same cycle. In that cycle, one counter must reload while all the others count down. The bench forces this case with directed steps in which `cell_valid` and `slot_tick` rise together while several layers are already locked at different counts. Random stimulus then produces it often. A behavioural model keeps one integer per layer and applies reload-before-decrement. Every cycle the bench compares the free mask, the found flag and the index against that model, so a wrong precedence shows up as a layer freed one slot early or late.

// File: rtl/lane_sel_pkg.sv
package lane_sel_pkg;

  // Width able to hold counts 0 .. hold-1
  function automatic int ctr_bits(input int hold);
    return (hold > 2) ? $clog2(hold) : 1;
  endfunction

  // Width of a layer index
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lane_hold_ctr.sv
module lane_hold_ctr #(
  parameter int HOLD = 4,
  parameter int CW   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  output logic busy
);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= RELOAD;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/lane_mask_merge.sv
module lane_mask_merge #(
  parameter int N = 8,
  parameter int F = 2
) (
  input  logic [N-1:0]   free_in,
  input  logic [F-1:0]   dest_en,
  input  logic [F*N-1:0] dest_mask,
  output logic [N-1:0]   cand
);
  always_comb begin
    cand = free_in;
    for (int f = 0; f < F; f++) begin
      if (dest_en[f]) cand = cand & dest_mask[f*N +: N];
    end
  end
endmodule

// File: rtl/lane_first_pick.sv
module lane_first_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
    any = |cand;
  end
endmodule

// File: rtl/lane_select.sv
module lane_select
  import lane_sel_pkg::*;
#(
  parameter int NUM_LAYERS = 8,
  parameter int HOLD_SLOTS = 4,
  parameter int FANOUT     = 2,
  localparam int IDX_W     = idx_bits(NUM_LAYERS),
  localparam int CNT_W     = ctr_bits(HOLD_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         slot_tick,
  input  logic                         cell_valid,
  input  logic [FANOUT-1:0]            dest_en,
  input  logic [FANOUT*NUM_LAYERS-1:0] dest_mask,
  output logic                         pick_found,
  output logic [IDX_W-1:0]             pick_layer,
  output logic [NUM_LAYERS-1:0]        avail_mask
);
  logic [NUM_LAYERS-1:0] busy_vec;
  logic [NUM_LAYERS-1:0] cand_vec;
  logic [NUM_LAYERS-1:0] load_vec;
  logic                  cand_any;
  logic [IDX_W-1:0]      cand_idx;
  logic                  accept;

  assign avail_mask = ~busy_vec;

  lane_mask_merge #(.N(NUM_LAYERS), .F(FANOUT)) u_merge (
    .free_in   (avail_mask),
    .dest_en   (dest_en),
    .dest_mask (dest_mask),
    .cand      (cand_vec)
  );

  lane_first_pick #(.N(NUM_LAYERS), .IW(IDX_W)) u_pick (
    .cand (cand_vec),
    .any  (cand_any),
    .idx  (cand_idx)
  );

  assign accept     = cell_valid & cand_any;
  assign pick_found = accept;
  assign pick_layer = accept ? cand_idx : '0;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    assign load_vec[l] = accept && (cand_idx == IDX_W'(l));
    lane_hold_ctr #(.HOLD(HOLD_SLOTS), .CW(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (slot_tick),
      .load  (load_vec[l]),
      .busy  (busy_vec[l])
    );
  end
endmodule

// File: rtl/lane_select_chk.sv
module lane_select_chk #(
  parameter int NUM_LAYERS = 8,
  parameter int HOLD_SLOTS = 4,
  parameter int FANOUT     = 2,
  parameter int IDX_W      = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         slot_tick,
  input logic                         cell_valid,
  input logic [FANOUT-1:0]            dest_en,
  input logic [FANOUT*NUM_LAYERS-1:0] dest_mask,
  input logic                         pick_found,
  input logic [IDX_W-1:0]             pick_layer,
  input logic [NUM_LAYERS-1:0]        avail_mask,
  input logic [NUM_LAYERS-1:0]        load_vec
);
  logic dest_ok;
  always_comb begin
    dest_ok = 1'b1;
    for (int f = 0; f < FANOUT; f++) begin
      if (dest_en[f] && !dest_mask[f*NUM_LAYERS + int'(pick_layer)]) dest_ok = 1'b0;
    end
  end

  // R3
  pick_in_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> (avail_mask[pick_layer] && dest_ok));

  // R5
  idle_no_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_valid |-> (!pick_found && pick_layer == '0));

  // R5
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_tick && !pick_found) |=> $stable(avail_mask));

  // R6
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec) && (pick_found == (load_vec != '0)));

  if (HOLD_SLOTS > 1) begin : g_lock
    // R6
    lock_after_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found |=> !avail_mask[$past(pick_layer)]);
  end

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_rise
    // R2
    free_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(avail_mask[l]) |-> $past(slot_tick));
  end
endmodule

bind lane_select lane_select_chk #(
  .NUM_LAYERS (NUM_LAYERS),
  .HOLD_SLOTS (HOLD_SLOTS),
  .FANOUT     (FANOUT),
  .IDX_W      (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_tick  (slot_tick),
  .cell_valid (cell_valid),
  .dest_en    (dest_en),
  .dest_mask  (dest_mask),
  .pick_found (pick_found),
  .pick_layer (pick_layer),
  .avail_mask (avail_mask),
  .load_vec   (load_vec)
);

// File: tb/sim_lane_select.sv
`timescale 1ns/1ps
module sim_lane_select;
  localparam int N  = 8;
  localparam int H  = 4;
  localparam int F  = 2;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           slot_tick = 1'b0;
  logic           cell_valid = 1'b0;
  logic [F-1:0]   dest_en = '0;
  logic [F*N-1:0] dest_mask = '0;
  logic           pick_found;
  logic [IW-1:0]  pick_layer;
  logic [N-1:0]   avail_mask;

  int checks = 0;
  int errors = 0;
  int lock_left [N];
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_select #(.NUM_LAYERS(N), .HOLD_SLOTS(H), .FANOUT(F)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .cell_valid(cell_valid),
    .dest_en(dest_en), .dest_mask(dest_mask), .pick_found(pick_found),
    .pick_layer(pick_layer), .avail_mask(avail_mask)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare against model, advance model at the edge.
  task automatic step(input bit v, input bit t, input logic [F-1:0] en,
                      input logic [F*N-1:0] m);
    int exp_free, exp_idx;
    bit exp_found;
    @(negedge clk);
    cell_valid = v; slot_tick = t; dest_en = en; dest_mask = m;
    #5;
    exp_free = 0;
    for (int l = 0; l < N; l++) if (lock_left[l] == 0) exp_free |= (1 << l);
    exp_found = 1'b0; exp_idx = 0;
    if (v) begin
      for (int l = 0; l < N && !exp_found; l++) begin
        bit ok = (lock_left[l] == 0);
        for (int f = 0; f < F; f++) if (en[f] && !m[f*N + l]) ok = 1'b0;
        if (ok) begin exp_found = 1'b1; exp_idx = l; end
      end
    end
    check("R2 free mask", int'(avail_mask), exp_free);
    check("R3/R5 found", int'(pick_found), int'(exp_found));
    check("R4/R5 index", int'(pick_layer), exp_idx);
    @(posedge clk);
    for (int l = 0; l < N; l++) begin
      if (exp_found && l == exp_idx) lock_left[l] = H - 1;   // R7 reload wins
      else if (t && lock_left[l] > 0) lock_left[l]--;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < N; l++) lock_left[l] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 free after reset", int'(avail_mask), 8'hFF);
    check("R1 found low", int'(pick_found), 0);

    // R4 unconstrained picks take 0,1,2 in turn; R6 locks hold
    step(1, 0, 2'b00, '0);
    step(1, 0, 2'b00, '0);
    step(1, 0, 2'b00, '0);
    // R3 one enabled mask, the disabled one is all zero and ignored
    step(1, 0, 2'b01, {8'h00, 8'hF0});
    // R3 multicast: intersection of both masks
    step(1, 0, 2'b11, {8'hC0, 8'hE0});
    // R5 empty intersection: no lock
    step(1, 0, 2'b11, {8'h0F, 8'hF0});
    step(0, 0, 2'b00, '0);
    // R7 accept and tick together with several locks in flight
    step(1, 1, 2'b00, '0);
    step(0, 1, 2'b00, '0);
    step(1, 1, 2'b10, {8'h01, 8'h00});
    // R8 idle ticks free everything; R6 exact release timing
    for (int i = 0; i < H + 1; i++) step(0, 1, 2'b00, '0);
    step(1, 1, 2'b00, '0);
    step(0, 0, 2'b00, '0);
    step(0, 1, 2'b00, '0);
    step(0, 1, 2'b00, '0);
    step(0, 0, 2'b00, '0);
    step(0, 1, 2'b00, '0);
    step(0, 0, 2'b00, '0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [F*N-1:0] m;
      m = F*N'($urandom);
      step(($urandom % 4) != 0, ($urandom % 3) == 0, F'($urandom), m | F*N'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule